// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat memory burst. A burst begins when the controller presents a full address and drives the load/advance control low. The block captures that address. On each later cycle with the control high, the block steps to the next beat. The upper address bits stay at the captured value. The two low bits follow one of two orders, chosen by a static mode input: an interleaved order, where the low bits are the start value XOR the beat index, or a linear order, where the low bits count up modulo four from the start value.

A stall input freezes the block for that clock edge. While it is high, neither a load nor an advance takes effect. The current address and the beat index are both outputs, so the memory-side logic can use either one. The address comes straight from registers through a small mapping, with no extra pipeline stage.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears the captured address and the beat index. After that edge, `cur_addr` is 0 and `beat` is 0.
- R2: At an edge where `stall` is 0 and `advance` is 0, the block captures `ext_addr` and sets `beat` to 0. After that edge, `cur_addr` equals the captured `ext_addr`.
- R3: When `interleave` is 1, the two low bits of `cur_addr` equal the captured start low bits XOR `beat`. For a start of 01 this gives 01, 00, 11, 10.
- R4: When `interleave` is 0, the two low bits of `cur_addr` equal (start low bits + `beat`) modulo 4. For a start of 01 this gives 01, 10, 11, 00.
- R5: At an edge where `stall` is 0 and `advance` is 1, `beat` increases by one modulo 4. After beat 3 it returns to 0 and keeps cycling while advances continue.
- R6: At an edge where `stall` is 1, the block ignores `advance` and `ext_addr`. The captured address and `beat` keep their values.
- R7: The bits of `cur_addr` above bit 1 equal the upper bits of the last captured address for every beat of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | 1 = ignore this clock edge and hold all state |
| advance | input | 1 | 0 = load a new burst from `ext_addr`, 1 = step to the next beat |
| interleave | input | 1 | Static order select: 1 = interleaved (XOR), 0 = linear (wrapping count) |
| ext_addr | input | ADDR_W | External start address of a new burst |
| cur_addr | output | ADDR_W | Address of the current beat |
| beat | output | 2 | Index of the current beat within the burst, 0 to 3 |

## Verification
The assertions check these rules on every cycle: the beat index steps modulo four on an advance, a load clears the beat index and captures the address, a stall freezes all state, the upper bits stay fixed while the burst advances, and beat 0 always puts out the start address. Whether the low bits follow the correct interleaved or linear sequence for each start value, and whether the mode input selects the right order, is shown only by the bench. The bench compares every cycle against its own model, across random stimulus and directed sequences from each start value.

// File: rtl/burst_seq_pkg.sv
// Shared definitions for the burst address sequencer.
// Assumes bursts are always four beats, so the beat index is two bits wide.
package burst_seq_pkg;
    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;
    typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/bs_beat_ctr.sv
// Beat index counter for one burst.
// Assumes load and advance share one control: a load clears the index and an
// advance increments it modulo BEATS. A stall freezes the index.
module bs_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stall,
    input  logic  advance,
    output beat_t beat_q
);

    // Update the beat index on load, advance or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (!stall) begin
            if (!advance) beat_q <= '0;
            else          beat_q <= beat_q + beat_t'(1);
        end
    end

    // R5: an advance moves the index on by one, wrapping after the last beat
    a_r5_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance) |=> (beat_q == beat_t'($past(beat_q) + beat_t'(1))));

    // R2: a load returns the index to the first beat
    a_r2_load_clears_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !advance) |=> (beat_q == '0));

    // R6: a stalled edge leaves the index untouched
    a_r6_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(beat_q));

endmodule

// File: rtl/bs_base_reg.sv
// Holds the start address of the current burst.
// Assumes the address is only captured on a load that is not stalled. The
// register keeps its value through advances.
module bs_base_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              advance,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_q
);

    // Capture the external address when a burst begins.
    always_ff @(posedge clk) begin
        if (!rst_n)                  base_q <= '0;
        else if (!stall && !advance) base_q <= ext_addr;
    end

    // R2: a load takes the address presented on that edge
    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !advance) |=> (base_q == $past(ext_addr)));

    // R6: a stalled edge leaves the start address untouched
    a_r6_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(base_q));

endmodule

// File: rtl/bs_order_map.sv
// Maps the start low bits and the beat index to the low address bits.
// Assumes the mode input is static during a burst. Both orders are computed
// and the mode picks one of them.
module bs_order_map
    import burst_seq_pkg::*;
(
    input  beat_t start_lo,
    input  beat_t beat,
    input  logic  interleave,
    output beat_t addr_lo
);

    beat_t xor_lo;
    beat_t lin_lo;

    // Compute both orders and select one by mode.
    always_comb begin
        xor_lo  = start_lo ^ beat;
        lin_lo  = start_lo + beat;
        addr_lo = interleave ? xor_lo : lin_lo;
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Four-beat burst address sequencer.
// Assumes ADDR_W is at least 3. The upper bits come from the captured start
// address, and the low bits follow the order picked by the interleave input.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              advance,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [1:0]        beat
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    beat_t             beat_q;
    beat_t             addr_lo;

    bs_beat_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .advance (advance),
        .beat_q  (beat_q)
    );

    bs_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .advance  (advance),
        .ext_addr (ext_addr),
        .base_q   (base_q)
    );

    bs_order_map u_map (
        .start_lo   (base_q[BEAT_W-1:0]),
        .beat       (beat_q),
        .interleave (interleave),
        .addr_lo    (addr_lo)
    );

    // Join the held upper bits with the ordered low bits.
    always_comb begin
        cur_addr = {base_q[ADDR_W-1:BEAT_W], addr_lo};
        beat     = beat_q;
    end

    // R3 / R4: in either order, the first beat puts out the start address
    a_r3_first_beat_start: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_q == '0) |-> (addr_lo == base_q[BEAT_W-1:0]));

    // R7: the upper bits do not move while the burst advances
    a_r7_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W])));

    // R1: the cycle after reset shows a zero address and the first beat
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cur_addr == '0 && beat == 2'd0));

    initial begin
        a_r7_width_ok: assert (HI_W >= 1);
    end

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          advance = 1'b0;
    logic          interleave = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] cur_addr;
    logic [1:0]    beat;

    int checks = 0;
    int fails  = 0;

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = 2'd0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall), .advance(advance),
        .interleave(interleave), .ext_addr(ext_addr),
        .cur_addr(cur_addr), .beat(beat)
    );

    function automatic logic [1:0] exp_lo(input logic [1:0] s, input logic [1:0] k,
                                          input logic ilv);
        if (ilv) return s ^ k;
        return 2'((s + k) % 4);
    endfunction

    task automatic check(input string req, input logic [AW-1:0] exp_a,
                         input logic [1:0] exp_b);
        checks++;
        if (cur_addr !== exp_a || beat !== exp_b) begin
            fails++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, cur_addr, beat, exp_a, exp_b);
        end
    endtask

    // Apply one cycle of stimulus, update the model, and check at the next negedge.
    task automatic step(input logic st, input logic adv, input logic [AW-1:0] a,
                        input string req);
        stall = st; advance = adv; ext_addr = a;
        @(posedge clk);
        if (!rst_n) begin
            m_base = '0; m_beat = 2'd0;
        end else if (!st) begin
            if (!adv) begin m_base = a; m_beat = 2'd0; end
            else m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
        check(req, {m_base[AW-1:2], exp_lo(m_base[1:0], m_beat, interleave)}, m_beat);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        @(negedge clk);
        // R1: reset state, with inputs that would otherwise load
        step(1'b0, 1'b0, 16'hBEEF, "R1");
        step(1'b0, 1'b1, 16'h1234, "R1");
        rst_n = 1'b1;

        // R2 R3: interleaved from start 01 -> 01,00,11,10, then R5 wrap
        interleave = 1'b1;
        step(1'b0, 1'b0, 16'hA5A1, "R2");
        step(1'b0, 1'b1, 16'h0000, "R3");
        step(1'b0, 1'b1, 16'hFFFF, "R3");
        step(1'b0, 1'b1, 16'h0000, "R3");
        step(1'b0, 1'b1, 16'h0000, "R5");
        if (cur_addr[1:0] !== 2'b01) begin
            checks++; fails++;
            $display("FAIL R5: wrap low=%b expected 01", cur_addr[1:0]);
        end else checks++;

        // R4: linear from start 01 -> 01,10,11,00, and R7 upper held
        interleave = 1'b0;
        step(1'b0, 1'b0, 16'h3C01, "R2");
        step(1'b0, 1'b1, 16'h0000, "R4");
        step(1'b0, 1'b1, 16'h0000, "R4");
        step(1'b0, 1'b1, 16'h0000, "R4");
        if (cur_addr !== 16'h3C00) begin
            checks++; fails++;
            $display("FAIL R4 R7: addr=%h expected 3c00", cur_addr);
        end else checks++;

        // R6: stall with a pending load and with an advance changes nothing
        step(1'b1, 1'b0, 16'h7777, "R6");
        step(1'b1, 1'b1, 16'h1111, "R6");
        step(1'b0, 1'b1, 16'h0000, "R5");

        // Directed: every start value in both orders through a full wrap
        for (int m = 0; m < 2; m++) begin
            interleave = m[0];
            for (int s = 0; s < 4; s++) begin
                step(1'b0, 1'b0, 16'h8000 | 16'(s), "R2");
                for (int k = 0; k < 5; k++)
                    step(1'b0, 1'b1, 16'h0000, m[0] ? "R3" : "R4");
            end
        end

        // Reset in mid-burst
        step(1'b0, 1'b0, 16'h4442, "R2");
        step(1'b0, 1'b1, 16'h0000, "R5");
        rst_n = 1'b0;
        step(1'b0, 1'b1, 16'h0000, "R1");
        rst_n = 1'b1;

        // Constrained random traffic; mode changes only at a load
        for (int i = 0; i < 3000; i++) begin
            logic st, adv;
            st  = ($urandom % 5) == 0;
            adv = ($urandom % 4) != 0;
            if (!st && !adv && ($urandom % 3) == 0) interleave = $urandom % 2;
            step(st, adv, 16'($urandom), st ? "R6" : (adv ? "R7" : "R2"));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule